// File: doc/BRIEF.md
# Pointer Load Delta Predictor

This block predicts the value that a pointer-producing load will return when that load misses in the last-level cache while the core is running ahead speculatively. For each static load, found by its program counter, it keeps the last difference between the load's effective address and the data the load returned. It also keeps a small saturating confidence count that shows whether that difference repeats. Linked structures that are allocated regularly give a fixed difference even when the pointer values themselves have no stride, so a fixed difference is enough to rebuild the pointer from the address.

Completed loads train the table through the training port. Training comes with a flag from outside logic saying the load feeds a later address computation, and with a poison flag for results that depend on an outstanding miss. The lookup port is combinational. When a speculative-mode miss finds a confident entry, the block returns the effective address minus the stored difference in the same cycle.

Top module: `avd_predictor`

## Requirements
- R1: The stored difference is training address minus training data, modulo 2^32. The predicted value is lookup address minus the stored difference, modulo 2^32.
- R2: `pred_vld` is 1 only while `lkp_vld`, `lkp_spec` and `lkp_miss` are all 1.
- R3: `pred_vld` is also 1 only when the indexed entry is valid, its tag equals the lookup tag, and its confidence is 2 or more.
- R4: A training write that hits a valid entry with an equal difference raises the confidence by one. The confidence saturates at 3.
- R5: A training write that hits a valid entry with a different difference stores the new difference and sets the confidence to 0.
- R6: A training write that finds the entry invalid, or holding another tag, allocates it with the new tag and difference and a confidence of 0.
- R7: Training has no effect when `trn_is_ptr` is 0 or `trn_poison` is 1.
- R8: The table has 16 direct-mapped entries. The index is PC bits [5:2] and the tag is PC bits [31:6].
- R9: A lookup resolves in the same cycle from the table state. A training write takes effect at the next rising clock edge, so a lookup in the same cycle sees the old entry.
- R10: After reset every entry is invalid and no prediction is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trn_vld | input | 1 | Training request |
| trn_pc | input | 32 | PC of the completed load |
| trn_addr | input | 32 | Effective address of the completed load |
| trn_data | input | 32 | Value the load returned |
| trn_is_ptr | input | 1 | Load result feeds an address computation |
| trn_poison | input | 1 | Result depends on an outstanding miss |
| lkp_vld | input | 1 | Lookup request |
| lkp_pc | input | 32 | PC of the missing load |
| lkp_addr | input | 32 | Effective address of the missing load |
| lkp_spec | input | 1 | Core is in speculative run-ahead mode |
| lkp_miss | input | 1 | Load missed in the last-level cache |
| pred_vld | output | 1 | Prediction is valid |
| pred_val | output | 32 | Predicted load value |

## Verification
The directed sequences cover three kinds of traffic. A striding list traversal and a leaf pattern whose addresses jump but whose difference stays fixed must both reach a prediction after three trainings, which shows the block keys on the difference and not on a stride. A run that alternates between two differences must never predict. Separate cases check that a non-speculative lookup, a cache hit, a poisoned load, a data load and a PC that aliases to the same index each behave as required. A same-cycle train and lookup checks that the lookup sees the old entry. Random traffic over a few PCs that share indices, with a few differences, is then compared against a reference table kept in the bench.

// File: rtl/avd_pkg.sv
package avd_pkg;
  localparam int unsigned AVD_PC_W     = 32;
  localparam int unsigned AVD_DATA_W   = 32;
  localparam int unsigned AVD_ENTRIES  = 16;
  localparam int unsigned AVD_CONF_W   = 2;
  localparam int unsigned AVD_PC_SHIFT = 2;

  function automatic logic [AVD_CONF_W-1:0] conf_bump(input logic [AVD_CONF_W-1:0] c);
    conf_bump = (&c) ? c : c + 1'b1;
  endfunction
endpackage

// File: rtl/avd_entry_bank.sv
module avd_entry_bank #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 26,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CONF_W  = 2,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_delta,
  input  logic [CONF_W-1:0] wr_conf,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_vld,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [DATA_W-1:0] ra_delta,
  output logic [CONF_W-1:0] ra_conf,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_vld,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [DATA_W-1:0] rb_delta,
  output logic [CONF_W-1:0] rb_conf
);
  logic [ENTRIES-1:0]             vld_q;
  logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
  logic [ENTRIES-1:0][DATA_W-1:0] delta_q;
  logic [ENTRIES-1:0][CONF_W-1:0] conf_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic ent_we;
    assign ent_we = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[e]  <= 1'b0;
        conf_q[e] <= '0;
      end else if (ent_we) begin
        vld_q[e]  <= 1'b1;
        conf_q[e] <= wr_conf;
      end
    end

    always_ff @(posedge clk) begin
      if (ent_we) begin
        tag_q[e]   <= wr_tag;
        delta_q[e] <= wr_delta;
      end
    end
  end

  always_comb begin
    ra_vld   = vld_q[ra_idx];
    ra_tag   = tag_q[ra_idx];
    ra_delta = delta_q[ra_idx];
    ra_conf  = conf_q[ra_idx];
    rb_vld   = vld_q[rb_idx];
    rb_tag   = tag_q[rb_idx];
    rb_delta = delta_q[rb_idx];
    rb_conf  = conf_q[rb_idx];
  end

  // R7 / R9: without a write the valid bits and confidences do not move
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(vld_q) && $stable(conf_q)));

  // R9: a write is visible as a valid entry after the next edge
  p_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/avd_train_ctl.sv
module avd_train_ctl
  import avd_pkg::*;
#(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CONF_W   = 2,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned PC_SHIFT = 2,
  localparam int unsigned TAG_W   = PC_W - IDX_W - PC_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trn_vld,
  input  logic [PC_W-1:0]   trn_pc,
  input  logic [DATA_W-1:0] trn_addr,
  input  logic [DATA_W-1:0] trn_data,
  input  logic              trn_is_ptr,
  input  logic              trn_poison,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_vld,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [DATA_W-1:0] rd_delta,
  input  logic [CONF_W-1:0] rd_conf,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_delta,
  output logic [CONF_W-1:0] wr_conf
);
  logic [DATA_W-1:0] new_delta;
  logic              tag_hit;
  logic              same_delta;

  always_comb begin
    rd_idx     = trn_pc[PC_SHIFT +: IDX_W];
    new_delta  = trn_addr - trn_data;
    tag_hit    = rd_vld && (rd_tag == trn_pc[PC_W-1 -: TAG_W]);
    same_delta = (rd_delta == new_delta);

    wr_en    = trn_vld && trn_is_ptr && !trn_poison;
    wr_idx   = rd_idx;
    wr_tag   = trn_pc[PC_W-1 -: TAG_W];
    wr_delta = new_delta;
    if (tag_hit && same_delta) wr_conf = conf_bump(rd_conf);
    else                       wr_conf = '0;
  end

  // R7: poisoned or non-pointer loads never reach the table
  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_vld && (!trn_is_ptr || trn_poison)) |-> !wr_en);

  // R6: a write to an entry that was not a hit starts at zero confidence
  p_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_vld) |-> (wr_conf == '0));
endmodule

// File: rtl/avd_lookup.sv
module avd_lookup #(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CONF_W    = 2,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned PC_SHIFT  = 2,
  parameter int unsigned CONF_THR  = 2,
  localparam int unsigned TAG_W    = PC_W - IDX_W - PC_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_vld,
  input  logic [PC_W-1:0]   lkp_pc,
  input  logic [DATA_W-1:0] lkp_addr,
  input  logic              lkp_spec,
  input  logic              lkp_miss,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_vld,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [DATA_W-1:0] rd_delta,
  input  logic [CONF_W-1:0] rd_conf,
  output logic              pred_vld,
  output logic [DATA_W-1:0] pred_val
);
  logic consult;
  logic stable_hit;

  always_comb begin
    rd_idx     = lkp_pc[PC_SHIFT +: IDX_W];
    consult    = lkp_vld && lkp_spec && lkp_miss;
    stable_hit = rd_vld && (rd_tag == lkp_pc[PC_W-1 -: TAG_W])
                 && (rd_conf >= CONF_W'(CONF_THR));
    pred_vld   = consult && stable_hit;
    pred_val   = lkp_addr - rd_delta;
  end

  // R2: predictions only for speculative-mode last-level misses
  p_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pred_vld |-> (lkp_vld && lkp_spec && lkp_miss));

  // R3: a prediction needs a valid entry at or above the threshold
  p_conf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pred_vld |-> (rd_vld && (rd_conf >= CONF_W'(CONF_THR))));
endmodule

// File: rtl/avd_predictor.sv
module avd_predictor
  import avd_pkg::*;
#(
  parameter int unsigned PC_W     = AVD_PC_W,
  parameter int unsigned DATA_W   = AVD_DATA_W,
  parameter int unsigned ENTRIES  = AVD_ENTRIES,
  parameter int unsigned CONF_W   = AVD_CONF_W,
  parameter int unsigned PC_SHIFT = AVD_PC_SHIFT,
  parameter int unsigned CONF_THR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trn_vld,
  input  logic [PC_W-1:0]   trn_pc,
  input  logic [DATA_W-1:0] trn_addr,
  input  logic [DATA_W-1:0] trn_data,
  input  logic              trn_is_ptr,
  input  logic              trn_poison,
  input  logic              lkp_vld,
  input  logic [PC_W-1:0]   lkp_pc,
  input  logic [DATA_W-1:0] lkp_addr,
  input  logic              lkp_spec,
  input  logic              lkp_miss,
  output logic              pred_vld,
  output logic [DATA_W-1:0] pred_val
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = PC_W - IDX_W - PC_SHIFT;

  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_delta;
  logic [CONF_W-1:0] wr_conf;

  logic [IDX_W-1:0]  t_idx, l_idx;
  logic              t_vld, l_vld;
  logic [TAG_W-1:0]  t_tag, l_tag;
  logic [DATA_W-1:0] t_delta, l_delta;
  logic [CONF_W-1:0] t_conf, l_conf;

  avd_entry_bank #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W), .CONF_W(CONF_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_delta(wr_delta), .wr_conf(wr_conf),
    .ra_idx(t_idx), .ra_vld(t_vld), .ra_tag(t_tag), .ra_delta(t_delta), .ra_conf(t_conf),
    .rb_idx(l_idx), .rb_vld(l_vld), .rb_tag(l_tag), .rb_delta(l_delta), .rb_conf(l_conf)
  );

  avd_train_ctl #(
    .PC_W(PC_W), .DATA_W(DATA_W), .CONF_W(CONF_W), .IDX_W(IDX_W), .PC_SHIFT(PC_SHIFT)
  ) u_train (
    .clk(clk), .rst_n(rst_n),
    .trn_vld(trn_vld), .trn_pc(trn_pc), .trn_addr(trn_addr), .trn_data(trn_data),
    .trn_is_ptr(trn_is_ptr), .trn_poison(trn_poison),
    .rd_idx(t_idx), .rd_vld(t_vld), .rd_tag(t_tag), .rd_delta(t_delta), .rd_conf(t_conf),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_delta(wr_delta), .wr_conf(wr_conf)
  );

  avd_lookup #(
    .PC_W(PC_W), .DATA_W(DATA_W), .CONF_W(CONF_W), .IDX_W(IDX_W),
    .PC_SHIFT(PC_SHIFT), .CONF_THR(CONF_THR)
  ) u_lookup (
    .clk(clk), .rst_n(rst_n),
    .lkp_vld(lkp_vld), .lkp_pc(lkp_pc), .lkp_addr(lkp_addr),
    .lkp_spec(lkp_spec), .lkp_miss(lkp_miss),
    .rd_idx(l_idx), .rd_vld(l_vld), .rd_tag(l_tag), .rd_delta(l_delta), .rd_conf(l_conf),
    .pred_vld(pred_vld), .pred_val(pred_val)
  );

  // R10: no prediction in the first cycle after reset release
  p_reset_r10: assert property (@(posedge clk)
    ($rose(rst_n)) |-> !pred_vld);
endmodule

// File: tb/avd_predictor_tb.sv
module avd_predictor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trn_vld = 0, trn_is_ptr = 0, trn_poison = 0;
  logic [31:0] trn_pc = 0, trn_addr = 0, trn_data = 0;
  logic        lkp_vld = 0, lkp_spec = 0, lkp_miss = 0;
  logic [31:0] lkp_pc = 0, lkp_addr = 0;
  logic        pred_vld;
  logic [31:0] pred_val;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit done = 0;

  // reference table
  bit          m_vld [16];
  logic [25:0] m_tag [16];
  logic [31:0] m_dlt [16];
  int          m_cnf [16];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  avd_predictor dut_i (
    .clk(clk), .rst_n(rst_n),
    .trn_vld(trn_vld), .trn_pc(trn_pc), .trn_addr(trn_addr), .trn_data(trn_data),
    .trn_is_ptr(trn_is_ptr), .trn_poison(trn_poison),
    .lkp_vld(lkp_vld), .lkp_pc(lkp_pc), .lkp_addr(lkp_addr),
    .lkp_spec(lkp_spec), .lkp_miss(lkp_miss),
    .pred_vld(pred_vld), .pred_val(pred_val)
  );

  function automatic bit exp_vld(logic [31:0] pc, bit v, bit s, bit m);
    int i = int'(pc[5:2]);
    return v && s && m && m_vld[i] && (m_tag[i] == pc[31:6]) && (m_cnf[i] >= 2);
  endfunction

  function automatic logic [31:0] exp_val(logic [31:0] pc, logic [31:0] a);
    return a - m_dlt[int'(pc[5:2])];
  endfunction

  task automatic model_train(logic [31:0] pc, logic [31:0] a, logic [31:0] d, bit ptr, bit psn);
    int i = int'(pc[5:2]);
    logic [31:0] nd = a - d;
    if (!ptr || psn) return;
    if (m_vld[i] && m_tag[i] == pc[31:6] && m_dlt[i] == nd) begin
      if (m_cnf[i] < 3) m_cnf[i]++;
    end else begin
      m_cnf[i] = 0;
    end
    m_vld[i] = 1; m_tag[i] = pc[31:6]; m_dlt[i] = nd;
  endtask

  task automatic chk(string req, bit ev, logic [31:0] evl);
    n_chk++;
    if (pred_vld !== ev || (ev && pred_val !== evl)) begin
      n_bad++;
      $display("FAIL %s: got vld=%0b val=%h, expected vld=%0b val=%h",
               req, pred_vld, pred_val, ev, evl);
    end
  endtask

  // one cycle: drive at negedge, check lookup, model the training write at the edge
  task automatic step(string req, bit tv, logic [31:0] tpc, logic [31:0] ta, logic [31:0] td,
                      bit tptr, bit tpsn, bit lv, logic [31:0] lpc, logic [31:0] la,
                      bit ls, bit lm, bit do_chk);
    @(negedge clk);
    trn_vld = tv; trn_pc = tpc; trn_addr = ta; trn_data = td;
    trn_is_ptr = tptr; trn_poison = tpsn;
    lkp_vld = lv; lkp_pc = lpc; lkp_addr = la; lkp_spec = ls; lkp_miss = lm;
    #2;
    if (do_chk) chk(req, exp_vld(lpc, lv, ls, lm), exp_val(lpc, la));
    @(posedge clk);
    if (tv) model_train(tpc, ta, td, tptr, tpsn);
  endtask

  task automatic train(logic [31:0] pc, logic [31:0] a, logic [31:0] d);
    step("train", 1, pc, a, d, 1, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic look(string req, logic [31:0] pc, logic [31:0] a, bit s, bit m);
    step(req, 0, 0, 0, 0, 0, 0, 1, pc, a, s, m, 1);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin m_vld[i] = 0; m_tag[i] = 0; m_dlt[i] = 0; m_cnf[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R10: empty table gives nothing
    look("R10", 32'h0000_1000, 32'h8000, 1, 1);

    // R1 R4 R8: striding list, delta -16
    train(32'h0000_1000, 32'h100, 32'h110);
    train(32'h0000_1000, 32'h110, 32'h120);
    look("R3 conf1", 32'h0000_1000, 32'h120, 1, 1);
    train(32'h0000_1000, 32'h120, 32'h130);
    look("R1 R4 stride", 32'h0000_1000, 32'h130, 1, 1);
    // R2: non-spec and cache hit
    look("R2 nonspec", 32'h0000_1000, 32'h130, 0, 1);
    look("R2 hit", 32'h0000_1000, 32'h130, 1, 0);
    step("R2 novld", 0, 0, 0, 0, 0, 0, 0, 32'h0000_1000, 32'h130, 1, 1, 1);

    // R1: leaf pattern, no stride, fixed delta +8
    train(32'h0000_2004, 32'h5008, 32'h5000);
    train(32'h0000_2004, 32'h9A08, 32'h9A00);
    train(32'h0000_2004, 32'h0308, 32'h0300);
    look("R1 leaf", 32'h0000_2004, 32'h7708, 1, 1);

    // R4 saturation then R5 replace
    repeat (4) train(32'h0000_2004, 32'h1008, 32'h1000);
    look("R4 sat", 32'h0000_2004, 32'h4448, 1, 1);
    train(32'h0000_2004, 32'h1000, 32'h1000);
    look("R5 replace", 32'h0000_2004, 32'h4448, 1, 1);
    train(32'h0000_2004, 32'h2000, 32'h2000);
    train(32'h0000_2004, 32'h3000, 32'h3000);
    look("R5 regain", 32'h0000_2004, 32'h4448, 1, 1);

    // R5: alternating deltas never predict
    for (int k = 0; k < 6; k++)
      train(32'h0000_3008, 32'h100, (k % 2) ? 32'h40 : 32'h80);
    look("R5 alt", 32'h0000_3008, 32'h900, 1, 1);

    // R7: poisoned and data loads leave the confident entry at PC 0x1000 alone
    step("R7", 1, 32'h0000_1000, 32'h0, 32'h5555, 1, 1, 0, 0, 0, 0, 0, 0);
    step("R7", 1, 32'h0000_1000, 32'h0, 32'h7777, 0, 0, 0, 0, 0, 0, 0, 0);
    look("R7 suppressed", 32'h0000_1000, 32'h200, 1, 1);

    // R6 R8: alias at same index [5:2]=0, different tag
    train(32'h0000_4000, 32'h10, 32'h0);
    look("R6 evict old", 32'h0000_1000, 32'h200, 1, 1);
    look("R6 new conf0", 32'h0000_4000, 32'h200, 1, 1);

    // R9: train and lookup together; lookup sees the old entry
    train(32'h0000_500C, 32'h40, 32'h0);
    train(32'h0000_500C, 32'h80, 32'h40);
    step("R9 same cycle", 1, 32'h0000_500C, 32'hC0, 32'h80, 1, 0,
         1, 32'h0000_500C, 32'h400, 1, 1, 1);
    look("R9 next edge", 32'h0000_500C, 32'h400, 1, 1);

    // random mix, all requirements
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] pcs [4];
      logic [31:0] ds [3];
      logic [31:0] a;
      pcs[0] = 32'h0000_0040; pcs[1] = 32'h0000_0080;
      pcs[2] = 32'h0000_0044; pcs[3] = 32'h0001_0040;
      ds[0] = 32'h10; ds[1] = 32'hFFFF_FFF0; ds[2] = 32'h8;
      a = $urandom;
      step("R1-mix", ($urandom % 4) != 0, pcs[$urandom % 4], a,
           a - ds[($urandom % 8 == 0) ? ($urandom % 3) : 0],
           ($urandom % 8) != 0, ($urandom % 8) == 0,
           ($urandom % 2) == 0, pcs[$urandom % 4], $urandom,
           ($urandom % 4) != 0, ($urandom % 4) != 0, 1);
    end

    // R10: reset again clears the table
    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < 16; i++) m_vld[i] = 0;
    @(negedge clk); rst_n = 1'b1;
    look("R10 after reset", 32'h0000_500C, 32'h400, 1, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule